// File: doc/BRIEF.md
# Edge Triggered Input Capture

This block records the instant at which an external signal changes. It has a 16-bit counter that starts at zero and advances by one on every clock. It also has a number of capture channels. Each channel watches one asynchronous pin. When the pin shows the transition that the channel is set up for, the channel stores the current counter value, raises its flag and, if its enable bit is set, drives the shared interrupt line. Software can then subtract two captured stamps to get periods or pulse widths.

The last channel shares its pin with another function. It samples edges only while a mode bit in the control word is set. While the bit is clear, the pin is left to its other user and the channel's stamp and flag do not change. All state is reached through a plain word-wide register port with a combinational read path and a single-cycle write strobe. There is no stream interface, so no valid/ready back-pressure applies.

Register addresses are:
- 0: control. Channel n's edge field sits at bits [2n+1:2n], and bit 8 is the shared-channel mode bit.
- 1: interrupt enables, at bits [3:0].
- 2: flags, at bits [3:0].
- 3: counter.
- 4 to 7: the stamps of channels 0 to 3.

Top module: `edge_capture_unit`

## Requirements
- R1: The counter resets to 0x0000, increases by one each clock and wraps from 0xFFFF to 0x0000. It appears on `count_o` and reads at address 3, and a write to address 3 leaves it unchanged.
- R2: Edge code 2'b01 captures rising edges and 2'b10 captures falling edges. The pin passes through two synchronizing flops. A level first sampled at clock edge k is captured at edge k+2, and the stamp holds the counter value seen on `count_o` during the cycle between edges k+1 and k+2.
- R3: Edge code 2'b00 disables capture on that channel, and code 2'b11 captures on both edges.
- R4: A capture sets the channel's flag, which reads at bits [3:0] of address 2. Writing 1 to a flag bit at address 2 clears it, and writing 0 leaves it unchanged.
- R5: If a capture and a clearing write for the same channel occur in the same cycle, the flag ends up set.
- R6: `irq_o` is high exactly when some channel has both its flag and its enable bit (address 1, bits [3:0]) set.
- R7: Channel 3 captures only while control bit 8 is 1. Edges on its pin while the bit is 0 leave its stamp and flag unchanged. Enabling the bit does not by itself cause a capture.
- R8: Stamps are read as one whole 16-bit word at addresses 4 to 7, and writes to those addresses have no effect.
- R9: After reset, all readable registers return zero. The control bits and enable bits read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 4 | Asynchronous capture pins, one per channel |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for `reg_addr_i` |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong edge decode, or a wrong synchronizer depth, shows up as a stamp that is off by a whole counter step. The stamp becomes visible at the capture address two cycles after the pin change is first sampled. A bad flag update shows on the flag read and on `irq_o` within one cycle of the capture or clearing write. The reference model predicts every readable word and the interrupt line on every cycle, so a divergence is reported at the first clock where it becomes visible.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_IEN   = 1;
  localparam int unsigned REG_FLAG  = 2;
  localparam int unsigned REG_COUNT = 3;
  localparam int unsigned CAP_BASE  = 4;

endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ecu_free_counter.sv
module ecu_free_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);

  logic [W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_q + 1'b1;
  end

  assign value = val_q;

endmodule

// File: rtl/ecu_capture_channel.sv
module ecu_capture_channel
  import ecu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_s,
  input  edge_sel_e        sel,
  input  logic             arm,
  input  logic [CNT_W-1:0] now,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] stamp,
  output logic             flag,
  output logic             hit
);

  logic             prev_q;
  logic             rise, fall, match;
  logic [CNT_W-1:0] stamp_q;
  logic             flag_q;

  // previous level keeps tracking even while disarmed, so arming never
  // produces a stale edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  assign rise = pin_s & ~prev_q;
  assign fall = ~pin_s & prev_q;

  always_comb begin
    unique case (sel)
      EDGE_RISE: match = rise;
      EDGE_FALL: match = fall;
      EDGE_BOTH: match = rise | fall;
      default:   match = 1'b0;
    endcase
  end

  assign hit = arm & match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (hit) stamp_q <= now;
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign stamp = stamp_q;
  assign flag  = flag_q;

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(CAP_BASE + NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cap_pin_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o
);

  localparam int SHARED   = NUM_CH - 1;
  localparam int MODE_BIT = 2 * NUM_CH;

  logic [CNT_W-1:0]        cnt_q;
  logic [NUM_CH-1:0]       pin_s;
  edge_sel_e               edge_cfg_q [NUM_CH];
  logic                    shared_mode_q;
  logic [NUM_CH-1:0]       ien_q;
  logic [NUM_CH-1:0]       flag_vec;
  logic [NUM_CH-1:0]       hit_vec;
  logic [CNT_W-1:0]        stamp [NUM_CH];
  logic [NUM_CH*CNT_W-1:0] cap_flat;
  logic [CNT_W-1:0]        ctrl_rd;
  logic                    wr_ctrl, wr_ien, wr_flag;
  logic                    wdata_unused;

  ecu_free_counter #(.W(CNT_W)) cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .value(cnt_q)
  );

  ecu_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cap_pin_i),
    .q    (pin_s)
  );

  assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_W'(REG_CTRL));
  assign wr_ien  = reg_wr_i && (reg_addr_i == ADDR_W'(REG_IEN));
  assign wr_flag = reg_wr_i && (reg_addr_i == ADDR_W'(REG_FLAG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) edge_cfg_q[c] <= EDGE_OFF;
      shared_mode_q <= 1'b0;
      ien_q         <= '0;
    end else begin
      if (wr_ctrl) begin
        for (int c = 0; c < NUM_CH; c++)
          edge_cfg_q[c] <= edge_sel_e'(reg_wdata_i[2*c +: 2]);
        shared_mode_q <= reg_wdata_i[MODE_BIT];
      end
      if (wr_ien) ien_q <= reg_wdata_i[NUM_CH-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic arm;
    if (g == SHARED) begin : g_shared
      assign arm = shared_mode_q;
    end else begin : g_dedicated
      assign arm = 1'b1;
    end

    ecu_capture_channel #(.CNT_W(CNT_W)) ch_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (pin_s[g]),
      .sel     (edge_cfg_q[g]),
      .arm     (arm),
      .now     (cnt_q),
      .flag_clr(wr_flag & reg_wdata_i[g]),
      .stamp   (stamp[g]),
      .flag    (flag_vec[g]),
      .hit     (hit_vec[g])
    );

    assign cap_flat[g*CNT_W +: CNT_W] = stamp[g];
  end

  always_comb begin
    ctrl_rd = '0;
    for (int c = 0; c < NUM_CH; c++) ctrl_rd[2*c +: 2] = edge_cfg_q[c];
    ctrl_rd[MODE_BIT] = shared_mode_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(REG_CTRL))  reg_rdata_o = ctrl_rd;
    if (reg_addr_i == ADDR_W'(REG_IEN))   reg_rdata_o[NUM_CH-1:0] = ien_q;
    if (reg_addr_i == ADDR_W'(REG_FLAG))  reg_rdata_o[NUM_CH-1:0] = flag_vec;
    if (reg_addr_i == ADDR_W'(REG_COUNT)) reg_rdata_o = cnt_q;
    for (int c = 0; c < NUM_CH; c++)
      if (reg_addr_i == ADDR_W'(CAP_BASE + c)) reg_rdata_o = stamp[c];
  end

  assign count_o      = cnt_q;
  assign irq_o        = |(flag_vec & ien_q);
  assign wdata_unused = ^{reg_wdata_i[CNT_W-1:MODE_BIT+1], hit_vec};

endmodule

// File: rtl/ecu_checker.sv
module ecu_checker
  import ecu_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CNT_W-1:0]        cnt,
  input logic [NUM_CH*CNT_W-1:0] cap_flat,
  input logic [NUM_CH-1:0]       flags,
  input logic [NUM_CH-1:0]       ien,
  input logic                    irq,
  input logic                    mode,
  input logic                    reg_wr,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [CNT_W-1:0]        reg_wdata
);

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ien) == '0) |-> !irq);

  assert_shared_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> $stable(cap_flat[(NUM_CH-1)*CNT_W +: CNT_W]));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_stamp_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_flat[g*CNT_W +: CNT_W]) |-> cap_flat[g*CNT_W +: CNT_W] == $past(cnt));

    assert_flag_on_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_flat[g*CNT_W +: CNT_W]) |-> flags[g]);

    assert_flag_clear_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[g]) |-> $past(reg_wr && reg_addr == ADDR_W'(REG_FLAG) && reg_wdata[g]));
  end

endmodule

bind edge_capture_unit ecu_checker #(
  .NUM_CH(NUM_CH),
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt      (cnt_q),
  .cap_flat (cap_flat),
  .flags    (flag_vec),
  .ien      (ien_q),
  .irq      (irq_o),
  .mode     (shared_mode_q),
  .reg_wr   (reg_wr_i),
  .reg_addr (reg_addr_i),
  .reg_wdata(reg_wdata_i)
);

// File: tb/edge_capture_unit_tb_top.sv
`timescale 1ns/1ps
module edge_capture_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pins = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rdata;
  logic [15:0] count;
  logic        irq;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string phase_tag = "";

  always #2.5 clk = ~clk;

  edge_capture_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_pin_i  (pins),
    .reg_wr_i   (bus_wr),
    .reg_addr_i (bus_addr),
    .reg_wdata_i(bus_wdata),
    .reg_rdata_o(rdata),
    .count_o    (count),
    .irq_o      (irq)
  );

  // behavioural reference model
  int unsigned m_cnt;
  logic [1:0]  m_cfg [4];
  bit          m_mode;
  bit [3:0]    m_ien, m_flag;
  bit [15:0]   m_cap [4];
  bit [3:0]    m_hist [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mode = 0; m_ien = 0; m_flag = 0;
      for (int i = 0; i < 4; i++) begin m_cfg[i] = 2'b00; m_cap[i] = 0; end
      for (int i = 0; i < 3; i++) m_hist[i] = 0;
    end else begin
      bit [3:0] clr;
      bit [3:0] hits;
      clr = (bus_wr && bus_addr == 3'd2) ? bus_wdata[3:0] : 4'h0;
      hits = 0;
      for (int i = 0; i < 4; i++) begin
        bit r, f, ok;
        r = m_hist[1][i] && !m_hist[2][i];
        f = !m_hist[1][i] && m_hist[2][i];
        ok = (i != 3) || m_mode;
        case (m_cfg[i])
          2'b01: hits[i] = ok && r;
          2'b10: hits[i] = ok && f;
          2'b11: hits[i] = ok && (r || f);
          default: hits[i] = 0;
        endcase
        if (hits[i]) m_cap[i] = m_cnt[15:0];
      end
      m_flag = (m_flag & ~clr) | hits;
      if (bus_wr && bus_addr == 3'd0) begin
        for (int i = 0; i < 4; i++) m_cfg[i] = bus_wdata[2*i +: 2];
        m_mode = bus_wdata[8];
      end
      if (bus_wr && bus_addr == 3'd1) m_ien = bus_wdata[3:0];
      m_hist[2] = m_hist[1];
      m_hist[1] = m_hist[0];
      m_hist[0] = pins;
      m_cnt = (m_cnt + 1) & 32'hFFFF;
    end
  end

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    logic [15:0] v;
    v = 0;
    case (a)
      3'd0: begin
        for (int i = 0; i < 4; i++) v[2*i +: 2] = m_cfg[i];
        v[8] = m_mode;
      end
      3'd1: v[3:0] = m_ien;
      3'd2: v[3:0] = m_flag;
      3'd3: v = m_cnt[15:0];
      default: v = m_cap[a - 3'd4];
    endcase
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      string t;
      if (phase_tag != "") t = phase_tag;
      else if (bus_addr == 3'd0 || bus_addr == 3'd1) t = "R9";
      else if (bus_addr == 3'd2) t = "R4";
      else if (bus_addr == 3'd3) t = "R1";
      else t = "R2";
      chk(t, "rdata", {16'h0, rdata}, {16'h0, exp_read(bus_addr)});
      chk("R1", "count_o", {16'h0, count}, m_cnt);
      chk("R6", "irq_o", {31'h0, irq}, {31'h0, |(m_flag & m_ien)});
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, int n = 1);
    bus_addr = a;
    cyc(n);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    cyc(5);
    phase_tag = "R9";
    for (int a = 0; a < 8; a++) rd(3'(a));
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd(3'(a));

    // R1: counter runs, write ignored
    phase_tag = "R1";
    rd(3, 4);
    wr(3, 16'h1234);
    rd(3, 6);

    // R2: ch0 rising, ch1 falling
    phase_tag = "R2";
    wr(0, 16'h0009);
    rd(0);
    pins = 4'b0011; rd(4, 4); rd(5, 2);
    pins = 4'b0000; rd(5, 4); rd(4, 2);
    rd(2);

    // R3: ch0 off, ch2 both edges
    phase_tag = "R3";
    wr(2, 16'h000F);
    wr(0, 16'h0030);
    for (int k = 0; k < 4; k++) begin
      pins[0] = ~pins[0]; pins[2] = ~pins[2];
      rd(6, 3 + k); rd(4); rd(2);
    end

    // R5: capture coincident with clear, several offsets
    phase_tag = "R5";
    wr(0, 16'h0003);
    for (int k = 0; k < 5; k++) begin
      pins[0] = ~pins[0];
      rd(2, k);
      wr(2, 16'h0001);
      rd(2, 2);
    end

    // R4: zero write keeps, one write clears
    phase_tag = "R4";
    pins[0] = ~pins[0]; rd(2, 4);
    wr(2, 16'h0000); rd(2);
    wr(2, 16'h0001); rd(2);

    // R6: enables drive interrupt
    phase_tag = "R6";
    wr(1, 16'h0005);
    pins[0] = ~pins[0]; rd(1, 4);
    wr(1, 16'h0000); rd(2, 2);
    wr(1, 16'h000F); rd(2, 2);
    wr(2, 16'h000F); rd(2, 2);

    // R7: shared channel gated by mode bit
    phase_tag = "R7";
    wr(0, 16'h00C0);
    for (int k = 0; k < 3; k++) begin pins[3] = ~pins[3]; rd(7, 3); rd(2); end
    wr(0, 16'h01C0); rd(7, 3); rd(2);
    for (int k = 0; k < 3; k++) begin pins[3] = ~pins[3]; rd(7, 3); rd(2); end

    // R8: stamps are read-only
    phase_tag = "R8";
    wr(4, 16'hBEEF); rd(4);
    wr(7, 16'h5A5A); rd(7);
    wr(6, 16'hFFFF); rd(6);

    // R1: wrap of the counter
    phase_tag = "R1";
    rd(3, 66000);

    // mixed random traffic
    phase_tag = "";
    for (int k = 0; k < 3000; k++) begin
      pins = 4'($urandom);
      if ($urandom_range(0, 7) == 0) wr(3'($urandom_range(0, 7)), 16'($urandom));
      else rd(3'($urandom_range(0, 7)));
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL all watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule